// File: doc/BRIEF.md
# ATAPI Programmed-I/O Packet Read Sequencer

This block is the device side of a packet-command read carried out by programmed I/O. The host first puts a transfer byte limit into two byte-wide limit registers, then writes the packet opcode to the command register. The device raises busy briefly and then asks for the command packet. The packet is twelve bytes long and the host sends it as six 16-bit writes to the data port. For a READ(10) packet the device reads the requested blocks from a block-addressed word source. It hands the data to the host in bursts, and no burst is longer than the limit.

Every burst starts with an interrupt and with the data-request status bit. A status read clears the interrupt. After the host has read the last word, the device raises one more interrupt and returns to the ready-only status. The word source sees a block number and a word index within the block. It returns a word together with a valid flag, and the device takes that word only when the host reads the data port.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 and the interrupt is low. Status bits are: 7 busy, 6 ready, 5 device fault, 3 data request, 0 error.
- R2: Writing 0xA0 to address 7 while feature bit 0 (address 1) is clear starts a packet command. After one or more busy cycles (status 0x80) the status reads 0x48 while the device waits for the packet.
- R3: If feature bit 0 is set when 0xA0 is written, no packet transfer starts. The status stays 0x40 and no interrupt is raised.
- R4: A command code other than 0xA0 is ignored. The status stays 0x40.
- R5: The packet is taken from six writes to address 0. Each write carries two packet bytes, the low byte first. Byte 0 is the opcode (0x28 means READ(10)). Bytes 2 to 5 hold the start block, most significant byte first. Bytes 7 and 8 hold the block count, most significant byte first. Data words leave the device in order: for each block starting at the start block, word 0 up to the last word of that block.
- R6: The limit is address 4 (low byte) and address 5 (high byte). The effective limit is the limit with bit 0 cleared. If that value is 0, the effective limit is 0xFFFE. Each burst carries the smaller of the remaining bytes and the effective limit.
- R7: Before each burst the interrupt rises and the status reads 0x48. The interrupt stays low while the host reads the words of a burst.
- R8: After the last word of the transfer the interrupt rises again and the status reads 0x40.
- R9: Reading the status register clears the interrupt.
- R10: A packet with an opcode other than 0x28, or with a block count of 0, ends at once. The device raises the completion interrupt, the status reads 0x40, and no data is transferred.
- R11: A data-port read while the source's valid flag is low consumes no word. The next read returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data (combinational) |
| intrq | output | 1 | Interrupt request to the host |
| src_blk | output | 32 | Block number requested from the source |
| src_widx | output | WIDX_W (10) | Word index within the block |
| src_ready | output | 1 | Device takes the presented word this cycle |
| src_valid | input | 1 | Source word is valid |
| src_word | input | 16 | Source data word |

## Verification
The bench uses 32-byte blocks. It sweeps block counts from one to three against limits of 0, 1, 2, 3, 6, 7, 16, 31, 32, 33, 40 and 0xFFFF, so that both single-burst and many-burst transfers occur. The limits 0 and 1 exercise the substitution of 0xFFFE. The odd limits show that rounding down to even changes where each burst boundary falls. A limit that divides the total evenly shows that no empty burst is added before the completion interrupt. The source word encodes the low bits of the block number and the word index, so a swapped start-block byte or a wrong word order shows up directly in the data. Malformed packets, a command written with the feature bit set, a foreign command code and a read with the source stalled are each tried on their own.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;
  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] OPC_PACKET = 8'hA0;
  localparam logic [7:0] OPC_READ10 = 8'h28;
  localparam logic [2:0] RA_DATA  = 3'd0;
  localparam logic [2:0] RA_FEAT  = 3'd1;
  localparam logic [2:0] RA_LIMLO = 3'd4;
  localparam logic [2:0] RA_LIMHI = 3'd5;
  localparam logic [2:0] RA_CMDST = 3'd7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ARM, PH_PKT, PH_DECODE, PH_SETUP, PH_XFER
  } phase_t;

  // Limit in words: limit rounded down to even; zero becomes 0xFFFE bytes.
  function automatic logic [15:0] eff_limit_words(input logic [15:0] lim);
    logic [15:0] even;
    even = lim & 16'hFFFE;
    if (even == 16'd0) even = 16'hFFFE;
    return even >> 1;
  endfunction

  function automatic logic [31:0] burst_words(input logic [31:0] rem_words,
                                              input logic [15:0] lim);
    logic [31:0] cap;
    cap = {16'd0, eff_limit_words(lim)};
    return (rem_words < cap) ? rem_words : cap;
  endfunction
endpackage

// File: rtl/atapi_pkt_rx.sv
module atapi_pkt_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic        last_word,
  output logic [7:0]  opc,
  output logic [31:0] lba,
  output logic [15:0] nblk
);
  logic [2:0] cnt_q;

  assign last_word = wr_en && (cnt_q == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      opc   <= '0;
      lba   <= '0;
      nblk  <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (wr_en && cnt_q < 3'd6) begin
      cnt_q <= cnt_q + 3'd1;
      case (cnt_q)
        3'd0: opc <= wdata[7:0];
        3'd1: lba[31:16] <= {wdata[7:0], wdata[15:8]};
        3'd2: lba[15:0]  <= {wdata[7:0], wdata[15:8]};
        3'd3: nblk[15:8] <= wdata[15:8];
        3'd4: nblk[7:0]  <= wdata[7:0];
        default: ;
      endcase
    end
  end

  AST_PKT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 3'd6); // R5
endmodule

// File: rtl/atapi_burst_ctr.sv
module atapi_burst_ctr #(
  parameter int WIDX_W = 10,
  parameter int NBLK_W = 16,
  localparam int REM_W = NBLK_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [31:0]       lba,
  input  logic [NBLK_W-1:0] nblk,
  input  logic [15:0]       lim,
  input  logic              kick,
  input  logic              accept,
  output logic [31:0]       blk,
  output logic [WIDX_W-1:0] widx,
  output logic              burst_start,
  output logic              burst_end,
  output logic              xfer_last
);
  import atapi_pio_pkg::*;

  logic [REM_W-1:0] rem_q;
  logic [15:0]      left_q;
  logic [REM_W-1:0] rem_after;

  assign rem_after   = rem_q - REM_W'(1);
  assign burst_end   = accept && (left_q == 16'd1);
  assign xfer_last   = burst_end && (rem_q == REM_W'(1));
  assign burst_start = kick || (burst_end && !xfer_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      left_q <= '0;
      blk    <= '0;
      widx   <= '0;
    end else if (load) begin
      rem_q  <= {nblk, {WIDX_W{1'b0}}};
      left_q <= '0;
      blk    <= lba;
      widx   <= '0;
    end else begin
      if (accept) begin
        rem_q  <= rem_after;
        left_q <= left_q - 16'd1;
        widx   <= widx + WIDX_W'(1);
        if (&widx) blk <= blk + 32'd1;
      end
      if (burst_start)
        left_q <= 16'(burst_words(32'(kick ? rem_q : rem_after), lim));
    end
  end

  AST_ACCEPT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> left_q != 16'd0); // R6
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (left_q != 16'd0) && (left_q <= eff_limit_words(lim))); // R6
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq #(
  parameter int BLK_BYTES = 2048,
  parameter int NBLK_W    = 16,
  localparam int BLK_WORDS = BLK_BYTES / 2,
  localparam int WIDX_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              intrq,
  output logic [31:0]       src_blk,
  output logic [WIDX_W-1:0] src_widx,
  output logic              src_ready,
  input  logic              src_valid,
  input  logic [15:0]       src_word
);
  import atapi_pio_pkg::*;

  phase_t      phase_q;
  logic        feat0_q;
  logic [15:0] lim_q, xlim_q;
  logic        intrq_q;
  logic [7:0]  status;

  logic wr_data, wr_cmd, rd_data, rd_stat, cmd_go;
  logic pkt_last, pkt_good, bad_pkt, load, kick, accept;
  logic burst_start, burst_end, xfer_last, intr_set;
  logic [7:0]  opc;
  logic [31:0] lba;
  logic [15:0] nblk16;

  assign wr_data = host_wr && host_addr == RA_DATA;
  assign wr_cmd  = host_wr && host_addr == RA_CMDST;
  assign rd_data = host_rd && host_addr == RA_DATA;
  assign rd_stat = host_rd && host_addr == RA_CMDST;
  assign cmd_go  = wr_cmd && phase_q == PH_IDLE &&
                   host_wdata[7:0] == OPC_PACKET && !feat0_q;

  assign pkt_good = opc == OPC_READ10 && nblk16 != 16'd0;
  assign load     = phase_q == PH_DECODE && pkt_good;
  assign bad_pkt  = phase_q == PH_DECODE && !pkt_good;
  assign kick     = phase_q == PH_SETUP;
  assign src_ready = phase_q == PH_XFER && rd_data;
  assign accept    = src_ready && src_valid;
  assign intr_set  = burst_start || xfer_last || bad_pkt;

  atapi_pkt_rx u_pkt (
    .clk(clk), .rst_n(rst_n), .clear(cmd_go),
    .wr_en(wr_data && phase_q == PH_PKT), .wdata(host_wdata),
    .last_word(pkt_last), .opc(opc), .lba(lba), .nblk(nblk16)
  );

  atapi_burst_ctr #(.WIDX_W(WIDX_W), .NBLK_W(NBLK_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .lba(lba),
    .nblk(NBLK_W'(nblk16)), .lim(xlim_q), .kick(kick), .accept(accept),
    .blk(src_blk), .widx(src_widx), .burst_start(burst_start),
    .burst_end(burst_end), .xfer_last(xfer_last)
  );

  always_comb begin
    case (phase_q)
      PH_IDLE:           status = ST_DRDY;
      PH_PKT, PH_XFER:   status = ST_DRDY | ST_DRQ;
      default:           status = ST_BSY;
    endcase
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == RA_CMDST)                         host_rdata = {8'd0, status};
    else if (host_addr == RA_DATA && phase_q == PH_XFER) host_rdata = src_word;
  end

  assign intrq = intrq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      feat0_q <= 1'b0;
      lim_q   <= '0;
      xlim_q  <= '0;
      intrq_q <= 1'b0;
    end else begin
      if (host_wr && host_addr == RA_FEAT)  feat0_q <= host_wdata[0];
      if (host_wr && host_addr == RA_LIMLO) lim_q[7:0]  <= host_wdata[7:0];
      if (host_wr && host_addr == RA_LIMHI) lim_q[15:8] <= host_wdata[7:0];
      if (intr_set)     intrq_q <= 1'b1;
      else if (rd_stat) intrq_q <= 1'b0;
      case (phase_q)
        PH_IDLE:   if (cmd_go) begin phase_q <= PH_ARM; xlim_q <= lim_q; end
        PH_ARM:    phase_q <= PH_PKT;
        PH_PKT:    if (pkt_last) phase_q <= PH_DECODE;
        PH_DECODE: phase_q <= pkt_good ? PH_SETUP : PH_IDLE;
        PH_SETUP:  phase_q <= PH_XFER;
        PH_XFER:   if (xfer_last) phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_INTR_AT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> intrq); // R7
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> phase_q == PH_IDLE && intrq); // R8
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !intr_set |=> !intrq); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready && !src_valid |=> $stable(src_widx) && $stable(src_blk)); // R11
  AST_FEATURE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && phase_q == PH_IDLE && feat0_q |=> phase_q == PH_IDLE); // R3
endmodule

// File: tb/atapi_pio_seq_test.sv
module atapi_pio_seq_test;
  localparam int WW = 4;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic intrq, src_ready, src_valid = 1;
  logic [31:0] src_blk;
  logic [WW-1:0] src_widx;
  logic [15:0] src_word;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  assign src_word = {src_blk[11:0], src_widx};

  atapi_pio_seq #(.BLK_BYTES(32), .NBLK_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .intrq(intrq), .src_blk(src_blk), .src_widx(src_widx),
    .src_ready(src_ready), .src_valid(src_valid), .src_word(src_word));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_wr = 0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_rd = 1; host_addr = a; #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 0;
  endtask

  task automatic wait_intr(output bit seen);
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk); seen = intrq;
    end
  endtask

  task automatic poll_ready(output logic [15:0] d);
    for (int i = 0; i < 8; i++) begin
      do_rd(3'd7, d);
      if (!d[7]) break;
    end
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba,
                          input logic [15:0] nb);
    do_wr(0, {8'h00, op});
    do_wr(0, {lba[23:16], lba[31:24]});
    do_wr(0, {lba[7:0], lba[15:8]});
    do_wr(0, {nb[15:8], 8'h00});
    do_wr(0, {8'h00, nb[7:0]});
    do_wr(0, 16'h0000);
  endtask

  function automatic logic [15:0] exp_word(input logic [31:0] lba, input int n);
    logic [31:0] b = lba + 32'(n / 16);
    return {b[11:0], 4'(n % 16)};
  endfunction

  task automatic run_xfer(input logic [31:0] lba, input logic [15:0] nb,
                          input logic [15:0] lim, input bit stall);
    logic [15:0] d;
    bit seen;
    int total, effw, done, bw;
    do_wr(4, {8'h0, lim[7:0]});
    do_wr(5, {8'h0, lim[15:8]});
    do_wr(1, 16'h0);
    do_wr(7, 16'h00A0);
    poll_ready(d);
    chk(d == 16'h0048, "R2 packet wait status", d, 16'h48);
    send_pkt(8'h28, lba, nb);
    total = nb * 16;
    effw = lim >> 1;
    if (effw == 0) effw = 32767;
    done = 0;
    wait_intr(seen);
    chk(seen, "R7 first burst interrupt", 32'(seen), 1);
    do_rd(7, d);
    chk(d == 16'h0048, "R7 burst status", d, 16'h48);
    chk(!intrq, "R9 status read clears", 32'(intrq), 0);
    while (done < total) begin
      bw = (total - done < effw) ? total - done : effw;
      for (int j = 0; j < bw; j++) begin
        if (stall && done == 0) begin
          src_valid = 0;
          do_rd(0, d);
          src_valid = 1;
          chk(d == exp_word(lba, 0), "R11 stalled read word", d, exp_word(lba, 0));
        end
        do_rd(0, d);
        chk(d == exp_word(lba, done), "R5 data word", d, exp_word(lba, done));
        done++;
        if (j < bw - 1) chk(!intrq, "R7 quiet within burst", 32'(intrq), 0);
      end
      chk(intrq, done == total ? "R8 completion interrupt" : "R6 burst boundary interrupt",
          32'(intrq), 1);
      do_rd(7, d);
      if (done == total) chk(d == 16'h0040, "R8 final status", d, 16'h40);
      else chk(d == 16'h0048, "R6 next burst status", d, 16'h48);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bit seen;
    logic [15:0] lims [12] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd6, 16'd7,
                               16'd16, 16'd31, 16'd32, 16'd33, 16'd40, 16'hFFFF};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!intrq, "R1 reset interrupt", 32'(intrq), 0);
    do_rd(7, d);
    chk(d == 16'h0040, "R1 reset status", d, 16'h40);

    // R3: feature bit 0 selects the other transfer mode
    do_wr(1, 16'h0001);
    do_wr(7, 16'h00A0);
    repeat (3) @(negedge clk);
    chk(!intrq, "R3 no interrupt", 32'(intrq), 0);
    do_rd(7, d);
    chk(d == 16'h0040, "R3 status idle", d, 16'h40);
    do_wr(1, 16'h0000);

    // R4: foreign command code
    do_wr(7, 16'h00EC);
    repeat (3) @(negedge clk);
    do_rd(7, d);
    chk(d == 16'h0040, "R4 ignored command", d, 16'h40);

    // R10: wrong opcode, then zero count
    for (int k = 0; k < 2; k++) begin
      do_wr(7, 16'h00A0);
      poll_ready(d);
      chk(d == 16'h0048, "R2 packet wait status", d, 16'h48);
      send_pkt(k == 0 ? 8'h12 : 8'h28, 32'h10, k == 0 ? 16'd1 : 16'd0);
      wait_intr(seen);
      chk(seen, "R10 immediate completion interrupt", 32'(seen), 1);
      do_rd(7, d);
      chk(d == 16'h0040, "R10 status", d, 16'h40);
    end

    for (int nb = 1; nb <= 3; nb++)
      for (int li = 0; li < 12; li++)
        run_xfer(32'h5A3C_0E71 + 32'(nb * 13 + li), 16'(nb), lims[li], li == 5);

    run_xfer(32'h0102_0304, 16'd2, 16'd16, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule